// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider

This block holds the digital counters of an integer-N frequency synthesizer. On the reference side, a counter divides the reference clock down to the phase-comparison rate of 1.728 MHz. The reference is either 10.368 MHz, which is divided by 6, or 13.824 MHz, which is divided by 8. On the oscillator side, a dual-modulus prescaler (divide by 32 or 33) is steered by a main counter and a swallow counter. Together they divide the halved oscillator clock by N = 32 * M + S. M is 86 to 89, picked by a 2-bit code, and S is 0 to 31. Each side emits a one-cycle pulse per divided period, for a phase/frequency detector that sits outside this block.

Within one output period, the prescaler runs in its divide-by-33 mode for S prescaler periods. It then runs in divide-by-32 mode for the remaining M - S periods. S is always below M, so this ordering always completes. Code changes wait for the end of the current output period, so the detector never sees a shortened or stretched comparison period.

The block also reports the channel position at the antenna, in 864 kHz steps. In transmit mode this equals N. In receive mode it is N - 1, because the receive local oscillator sits one step above the antenna frequency for the same channel. For example, channel 0 in receive uses M = 86 and S = 28, which gives N = 2780 and an antenna step of 2779. The same channel in transmit uses S = 27, which gives N = 2779 and an antenna step of 2779.

Top module: `pll_div_top`

## Requirements
- R1: While rst_ni is low and after release, both pulse outputs are 0 and ant_step_o is 2752, the value for main code 0, swallow 0 and transmit.
- R2: The oscillator-side pulse period in vco_clk_i cycles is 32 * (86 + main_code_i) + swallow_i. Main codes 0, 1, 2 and 3 select 86, 87, 88 and 89, and swallow_i is an unsigned 0 to 31.
- R3: main_code_i, swallow_i and rx_i are sampled only at the clock edge that ends an output period. Changing them in the middle of a period leaves that period's length unchanged.
- R4: div_pulse_o is high for exactly one vco_clk_i cycle per output period.
- R5: The reference-side pulse period in ref_clk_i cycles is 6 when ref_sel_i is 0 and 8 when it is 1.
- R6: ref_sel_i is sampled only at the edge that ends a reference period. A change in the middle of a period takes effect from the following period.
- R7: ant_step_o takes the value N - rx_i (rx_i = 1 means receive) in the cycle in which div_pulse_o rises, using the codes loaded at that edge. It holds that value until the next pulse.
- R8: ref_pulse_o is high for exactly one ref_clk_i cycle per reference period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset for both clock domains |
| vco_clk_i | input | 1 | Oscillator clock after the divide-by-two stage |
| ref_clk_i | input | 1 | Reference clock |
| main_code_i | input | 2 | Main-counter select (86 + code) |
| swallow_i | input | 5 | Swallow count, 0 to 31 |
| rx_i | input | 1 | 1 = receive, 0 = transmit |
| ref_sel_i | input | 1 | 0 = divide by 6, 1 = divide by 8 |
| div_pulse_o | output | 1 | One-cycle pulse per N oscillator cycles |
| ref_pulse_o | output | 1 | One-cycle pulse per reference division period |
| ant_step_o | output | 12 | Antenna channel position in 864 kHz steps |

## Verification
Any wrong internal count shows at the ports within one output period, as a gap between two div_pulse_o pulses that differs from 32 * M + S. For example, if a swallow count is off by one, the period moves by exactly one cycle. If codes are loaded in the middle of a period, the gap that straddles the change has the wrong length. The same fault also makes ant_step_o change while no pulse is present, which shows up within a few cycles. A fault in the reference counter shows up within eight reference cycles as a pulse gap other than 6 or 8.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int unsigned MAIN_W_D    = 2;
  localparam int unsigned SW_W_D      = 5;
  localparam int unsigned MAIN_BASE_D = 86;
  localparam int unsigned REF_LO_D    = 6;
  localparam int unsigned REF_HI_D    = 8;
  localparam int unsigned N_W_D       = 12;

  typedef enum logic {PRE_LOW = 1'b0, PRE_HIGH = 1'b1} pre_mode_e;
endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int unsigned LO = pll_div_pkg::REF_LO_D,
  parameter int unsigned HI = pll_div_pkg::REF_HI_D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(HI);

  logic [CW-1:0] cnt_q;
  logic          hi_q;
  logic          tc;

  assign tc = (cnt_q == (hi_q ? CW'(HI - 1) : CW'(LO - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      hi_q    <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tc;
      if (tc) begin
        cnt_q <= '0;
        hi_q  <= sel_i;  // ratio changes only at period end
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pll_prescaler.sv
module pll_prescaler #(
  parameter int unsigned SW_W = pll_div_pkg::SW_W_D
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  pll_div_pkg::pre_mode_e mode_i,
  output logic                   tc_o
);
  localparam int unsigned P_LO = 2 ** SW_W;
  localparam int unsigned PW   = $clog2(P_LO + 1);

  logic [PW-1:0] cnt_q;

  assign tc_o = (cnt_q == ((mode_i == pll_div_pkg::PRE_HIGH) ? PW'(P_LO) : PW'(P_LO - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (tc_o) cnt_q <= '0;
    else           cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/pll_swallow_ctrl.sv
module pll_swallow_ctrl #(
  parameter int unsigned MAIN_W    = pll_div_pkg::MAIN_W_D,
  parameter int unsigned SW_W      = pll_div_pkg::SW_W_D,
  parameter int unsigned MAIN_BASE = pll_div_pkg::MAIN_BASE_D,
  parameter int unsigned N_W       = pll_div_pkg::N_W_D
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tc_i,
  input  logic [MAIN_W-1:0]      main_code_i,
  input  logic [SW_W-1:0]        swallow_i,
  input  logic                   rx_i,
  output pll_div_pkg::pre_mode_e mode_o,
  output logic                   pulse_o,
  output logic [N_W-1:0]         ant_step_o
);
  localparam int unsigned P_LO   = 2 ** SW_W;
  localparam int unsigned M_MAX  = MAIN_BASE + 2 ** MAIN_W - 1;
  localparam int unsigned M_W    = $clog2(M_MAX + 1);
  localparam int unsigned N_RST  = MAIN_BASE * P_LO;

  logic [M_W-1:0]  cur_m_q;
  logic [M_W-1:0]  mc_q;
  logic [SW_W-1:0] sw_left_q;
  logic            last;
  logic [N_W-1:0]  n_next;

  assign mode_o = (sw_left_q != '0) ? pll_div_pkg::PRE_HIGH : pll_div_pkg::PRE_LOW;
  assign last   = (mc_q == cur_m_q - M_W'(1));
  assign n_next = N_W'((MAIN_BASE + 32'(main_code_i)) * P_LO + 32'(swallow_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_m_q    <= M_W'(MAIN_BASE);
      mc_q       <= '0;
      sw_left_q  <= '0;
      pulse_o    <= 1'b0;
      ant_step_o <= N_W'(N_RST);
    end else begin
      pulse_o <= tc_i && last;
      if (tc_i) begin
        if (last) begin
          // output period ends: take new codes
          mc_q       <= '0;
          cur_m_q    <= M_W'(MAIN_BASE + 32'(main_code_i));
          sw_left_q  <= swallow_i;
          ant_step_o <= n_next - N_W'(rx_i);
        end else begin
          mc_q <= mc_q + M_W'(1);
          if (sw_left_q != '0) sw_left_q <= sw_left_q - SW_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pll_div_top.sv
module pll_div_top #(
  parameter int unsigned MAIN_W    = pll_div_pkg::MAIN_W_D,
  parameter int unsigned SW_W      = pll_div_pkg::SW_W_D,
  parameter int unsigned MAIN_BASE = pll_div_pkg::MAIN_BASE_D,
  parameter int unsigned REF_LO    = pll_div_pkg::REF_LO_D,
  parameter int unsigned REF_HI    = pll_div_pkg::REF_HI_D,
  parameter int unsigned N_W       = pll_div_pkg::N_W_D
) (
  input  logic              rst_ni,
  input  logic              vco_clk_i,
  input  logic              ref_clk_i,
  input  logic [MAIN_W-1:0] main_code_i,
  input  logic [SW_W-1:0]   swallow_i,
  input  logic              rx_i,
  input  logic              ref_sel_i,
  output logic              div_pulse_o,
  output logic              ref_pulse_o,
  output logic [N_W-1:0]    ant_step_o
);
  pll_div_pkg::pre_mode_e pre_mode;
  logic                   pre_tc;

  pll_ref_div #(.LO(REF_LO), .HI(REF_HI)) u_ref (
    .clk_i   (ref_clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (ref_sel_i),
    .pulse_o (ref_pulse_o)
  );

  pll_prescaler #(.SW_W(SW_W)) u_pre (
    .clk_i  (vco_clk_i),
    .rst_ni (rst_ni),
    .mode_i (pre_mode),
    .tc_o   (pre_tc)
  );

  pll_swallow_ctrl #(
    .MAIN_W(MAIN_W), .SW_W(SW_W), .MAIN_BASE(MAIN_BASE), .N_W(N_W)
  ) u_ctrl (
    .clk_i       (vco_clk_i),
    .rst_ni      (rst_ni),
    .tc_i        (pre_tc),
    .main_code_i (main_code_i),
    .swallow_i   (swallow_i),
    .rx_i        (rx_i),
    .mode_o      (pre_mode),
    .pulse_o     (div_pulse_o),
    .ant_step_o  (ant_step_o)
  );
endmodule

// File: rtl/pll_div_chk.sv
module pll_div_chk #(
  parameter int unsigned MAIN_W    = 2,
  parameter int unsigned SW_W      = 5,
  parameter int unsigned MAIN_BASE = 86,
  parameter int unsigned REF_LO    = 6,
  parameter int unsigned REF_HI    = 8,
  parameter int unsigned N_W       = 12
) (
  input logic              rst_ni,
  input logic              vco_clk_i,
  input logic              ref_clk_i,
  input logic [MAIN_W-1:0] main_code_i,
  input logic [SW_W-1:0]   swallow_i,
  input logic              rx_i,
  input logic              ref_sel_i,
  input logic              div_pulse_o,
  input logic              ref_pulse_o,
  input logic [N_W-1:0]    ant_step_o
);
  localparam int unsigned P_LO = 2 ** SW_W;
  localparam int unsigned RW   = $clog2(REF_HI + 1);

  logic [MAIN_W-1:0] main_d;
  logic [SW_W-1:0]   sw_d;
  logic              rx_d;
  logic              sel_d;
  logic [N_W-1:0]    gap_q, exp_q, n_seen;
  logic [RW-1:0]     rgap_q, rexp_q;

  assign n_seen = N_W'((MAIN_BASE + 32'(main_d)) * P_LO + 32'(sw_d));

  always_ff @(posedge vco_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_d <= '0; sw_d <= '0; rx_d <= 1'b0;
      gap_q  <= '0;
      exp_q  <= N_W'(MAIN_BASE * P_LO);
    end else begin
      main_d <= main_code_i; sw_d <= swallow_i; rx_d <= rx_i;
      if (div_pulse_o) begin
        gap_q <= N_W'(1);
        exp_q <= n_seen;
      end else begin
        gap_q <= gap_q + N_W'(1);
      end
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_d  <= 1'b0;
      rgap_q <= '0;
      rexp_q <= RW'(REF_LO);
    end else begin
      sel_d <= ref_sel_i;
      if (ref_pulse_o) begin
        rgap_q <= RW'(1);
        rexp_q <= sel_d ? RW'(REF_HI) : RW'(REF_LO);
      end else begin
        rgap_q <= rgap_q + RW'(1);
      end
    end
  end

  // R2 R3
  div_period_chk: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    div_pulse_o |-> gap_q == exp_q);
  // R4
  div_width_chk: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    div_pulse_o |=> !div_pulse_o);
  // R7
  ant_hold_chk: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    !div_pulse_o |-> $stable(ant_step_o));
  // R7
  ant_value_chk: assert property (@(posedge vco_clk_i) disable iff (!rst_ni)
    div_pulse_o |-> ant_step_o == exp_q - N_W'(rx_d) + (n_seen - exp_q));
  // R5 R6
  ref_period_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_pulse_o |-> rgap_q == rexp_q);
  // R8
  ref_width_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_pulse_o |=> !ref_pulse_o);
endmodule

bind pll_div_top pll_div_chk #(
  .MAIN_W(MAIN_W), .SW_W(SW_W), .MAIN_BASE(MAIN_BASE),
  .REF_LO(REF_LO), .REF_HI(REF_HI), .N_W(N_W)
) u_chk (
  .rst_ni(rst_ni), .vco_clk_i(vco_clk_i), .ref_clk_i(ref_clk_i),
  .main_code_i(main_code_i), .swallow_i(swallow_i), .rx_i(rx_i),
  .ref_sel_i(ref_sel_i), .div_pulse_o(div_pulse_o),
  .ref_pulse_o(ref_pulse_o), .ant_step_o(ant_step_o)
);

// File: tb/sim_pll_div_top.sv
module sim_pll_div_top;
  logic        rst_ni = 1'b0;
  logic        vco_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic [1:0]  main_code = '0;
  logic [4:0]  swallow = '0;
  logic        rx = 1'b0;
  logic        ref_sel = 1'b0;
  logic        div_pulse, ref_pulse;
  logic [11:0] ant_step;

  int checks = 0;
  int errors = 0;
  longint vco_edges = 0;
  longint ref_edges = 0;
  bit done = 0;

  always #4 vco_clk = ~vco_clk;
  always #5 ref_clk = ~ref_clk;
  always @(posedge vco_clk) vco_edges++;
  always @(posedge ref_clk) ref_edges++;

  pll_div_top u0 (
    .rst_ni(rst_ni), .vco_clk_i(vco_clk), .ref_clk_i(ref_clk),
    .main_code_i(main_code), .swallow_i(swallow), .rx_i(rx),
    .ref_sel_i(ref_sel), .div_pulse_o(div_pulse), .ref_pulse_o(ref_pulse),
    .ant_step_o(ant_step)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_div(output longint t);
    @(negedge vco_clk);
    while (!div_pulse) @(negedge vco_clk);
    t = vco_edges;
  endtask

  task automatic wait_ref(output longint t);
    @(negedge ref_clk);
    while (!ref_pulse) @(negedge ref_clk);
    t = ref_edges;
  endtask

  function automatic int n_of(input int m, input int s);
    return 32 * (86 + m) + s;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    longint t0, t1;
    int cur_n, pend_n, pend_ant;
    int sw_set [3];
    sw_set = '{0, 1, 31};

    repeat (3) @(negedge vco_clk);
    // R1 reset state
    check("R1 div_pulse in reset", div_pulse, 0);
    check("R1 ref_pulse in reset", ref_pulse, 0);
    check("R1 ant_step in reset", ant_step, 2752);
    @(negedge vco_clk) rst_ni = 1'b1;
    @(negedge vco_clk);
    check("R1 ant_step after release", ant_step, 2752);

    // reference side: R5 R6 R8
    wait_ref(t0);
    @(negedge ref_clk) check("R8 ref width", ref_pulse, 0);
    wait_ref(t1);
    check("R5 ref ratio sel0", t1 - t0, 6);
    @(negedge ref_clk) begin
      check("R8 ref width", ref_pulse, 0);
      ref_sel = 1'b1;
    end
    t0 = t1;
    wait_ref(t1);
    check("R6 sel change deferred", t1 - t0, 6);
    t0 = t1;
    wait_ref(t1);
    check("R5 ref ratio sel1", t1 - t0, 8);
    @(negedge ref_clk) ref_sel = 1'b0;
    t0 = t1;
    wait_ref(t1);
    check("R6 sel back deferred", t1 - t0, 8);
    t0 = t1;
    wait_ref(t1);
    check("R5 ref ratio sel0 again", t1 - t0, 6);

    // oscillator side sweep: R2 R3 R4 R7
    wait_div(t0);
    check("R7 ant at first pulse", ant_step, 2752);
    @(negedge vco_clk) check("R4 div width", div_pulse, 0);
    cur_n = 2752;
    main_code = 2'd0; swallow = 5'(sw_set[0]); rx = 1'b0;
    pend_n = n_of(0, sw_set[0]);
    pend_ant = pend_n;
    for (int i = 0; i <= 41; i++) begin
      int m, s;
      wait_div(t1);
      check("R2 R3 div period", t1 - t0, cur_n);
      check("R7 ant_step at load", ant_step, pend_ant);
      t0 = t1;
      cur_n = pend_n;
      @(negedge vco_clk) check("R4 div width", div_pulse, 0);
      if (i + 1 < 12) begin m = (i + 1) / 3; s = sw_set[(i + 1) % 3]; end
      else if (i + 1 <= 40) begin m = 3; s = i + 1 - 10; end
      else begin m = 0; s = 0; end
      main_code = 2'(m); swallow = 5'(s); rx = 1'((i + 1) % 2);
      pend_n = n_of(m, s);
      pend_ant = pend_n - ((i + 1) % 2);
      repeat (5) @(negedge vco_clk);
      check("R7 ant_step held", ant_step, cur_n - (i % 2));
    end
    done = 1;
    finish_run();
  end
endmodule